// File: doc/BRIEF.md
# Data Memory Decoder with External Bus

This block sits between a small CPU core's data port and its memories. It divides a 16-bit data address into three regions. The lowest 96 locations hold the register file and I/O space. The next 512 locations hold internal SRAM. Every higher address belongs to an optional external SRAM. Internal accesses complete in one cycle: the block raises a select for the addressed region and passes that region's read data back to the core.

Accesses to the external region drive a separate address and data bus with active-low read and write strobes. The block stalls the core until the access is complete. The length of an external access depends on a 2-bit wait-state setting. With no wait states it lasts one clock longer than an internal access. Each configured wait state adds one more clock. A single enable bit turns the external bus on. When the enable bit is clear, an access above the internal space has no effect.

Top module: `dmem_decoder`

## Requirements
- R1: A read or write to addresses 0x0000–0x005F raises `regio_sel` in the same cycle and leaves `core_stall` low. A read returns `regio_rdata` on `core_rdata` in that cycle.
- R2: A read or write to addresses 0x0060–0x025F raises `isram_sel` in the same cycle and leaves `core_stall` low. A read returns `isram_rdata` on `core_rdata` in that cycle.
- R3: `ext_rd_n` and `ext_wr_n` stay high (inactive) for the whole of every internal access.
- R4: With `ext_en` = 1, an access to an address from 0x0260 to 0xFFFF goes to the external bus. No internal select is raised, and `ext_addr` carries the full 16-bit core address while the strobe is low.
- R5: With `wait_sel` = 0, an external access lasts 2 cycles. `core_stall` is high in the first cycle and low in the second.
- R6: With `wait_sel` = 1, 2 or 3, an external access lasts 3, 4 or 5 cycles. `core_stall` is high for 2, 3 or 4 consecutive cycles and low in the last cycle.
- R7: During an external read, `ext_rd_n` is low from the second cycle through the last cycle, and `ext_wr_n` stays high. In the last cycle, `core_rdata` equals `ext_dq_in`.
- R8: During an external write, `ext_wr_n` is low and `ext_dq_oe` is high from the second cycle through the last cycle. `ext_addr` and `ext_dq_out` (equal to the core write data) hold steady over that whole period. Both strobes are high again in the cycle after the access ends.
- R9: With `ext_en` = 0, an access above 0x025F is ignored. `core_stall` stays low, a read returns 0x00, no strobe goes low, and a write leaves external memory unchanged.
- R10: While `rst_n` is low at a clock edge, the block leaves the following state: `ext_rd_n` and `ext_wr_n` high, `ext_dq_oe` low and `ext_addr` 0x0000. Reset also abandons an external access that is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_addr | input | 16 | Core data address |
| core_wdata | input | 8 | Core write data |
| core_rd | input | 1 | Core read request |
| core_wr | input | 1 | Core write request |
| core_stall | output | 1 | Core must hold its request and wait |
| core_rdata | output | 8 | Read data returned to the core |
| ext_en | input | 1 | External bus enable |
| wait_sel | input | 2 | Number of external wait states (0–3) |
| regio_sel | output | 1 | Register file / I/O region selected |
| isram_sel | output | 1 | Internal SRAM selected |
| regio_rdata | input | 8 | Read data from register file / I/O |
| isram_rdata | input | 8 | Read data from internal SRAM |
| ext_addr | output | 16 | External bus address |
| ext_dq_out | output | 8 | External bus write data |
| ext_dq_oe | output | 1 | External data bus output enable |
| ext_dq_in | input | 8 | External bus read data |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The assertions assume a well-behaved core. It never raises `core_rd` and `core_wr` together. While `core_stall` is high, it holds address, write data, enables, `ext_en` and `wait_sel` unchanged. The bench respects both rules. It presents one access at a time, keeps every input fixed until it sees the stall drop, and drops the request for a cycle before the next access. The one exception is reset, which the bench applies in the middle of an external access.

// File: rtl/dmem_pkg.sv
// Shared types for the data memory decoder.
// Assumes nothing beyond the region set: three address regions, fixed order.
package dmem_pkg;
    typedef enum logic [1:0] {
        RGN_REGIO = 2'd0,
        RGN_ISRAM = 2'd1,
        RGN_EXT   = 2'd2
    } region_t;
endpackage

// File: rtl/dmem_region_dec.sv
// Region decoder: classifies a core address into register/I-O, internal
// SRAM or external space and raises the matching select for an active request.
// Assumes REGIO_SIZE + ISRAM_SIZE fits inside the address space.
module dmem_region_dec
    import dmem_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int REGIO_SIZE = 96,
    parameter int ISRAM_SIZE = 512
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              ext_en,
    output region_t           region,
    output logic              regio_sel,
    output logic              isram_sel,
    output logic              ext_req
);
    localparam logic [ADDR_W-1:0] ISRAM_BASE = ADDR_W'(REGIO_SIZE);
    localparam logic [ADDR_W-1:0] EXT_BASE   = ADDR_W'(REGIO_SIZE + ISRAM_SIZE);

    logic active;

    // Classify the address against the two fixed boundaries.
    always_comb begin
        if (addr < ISRAM_BASE)    region = RGN_REGIO;
        else if (addr < EXT_BASE) region = RGN_ISRAM;
        else                      region = RGN_EXT;
    end

    // Qualify the region with an active request and the external enable.
    always_comb begin
        active    = rd | wr;
        regio_sel = active && (region == RGN_REGIO);
        isram_sel = active && (region == RGN_ISRAM);
        ext_req   = active && (region == RGN_EXT) && ext_en;
    end
endmodule

// File: rtl/dmem_ext_ctrl.sv
// External bus sequencer: latches an external request, drives the bus with
// stable address/data, holds the strobe for 1 + wait-state cycles and stalls
// the core until the final cycle.
// Assumes the core holds its request steady while stall is high.
module dmem_ext_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    input  logic [WS_W-1:0]   ws,
    output logic              stall,
    output logic              busy,
    output logic              done,
    output logic              rd_latched,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_oe,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);
    localparam int CNT_W     = WS_W + 1;
    localparam int MAX_EXTRA = 2 ** WS_W;
    localparam int RUN_W     = CNT_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  extra;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_rd;
    logic              lat_wr;
    logic              start;

    // Extra cycles over an internal access: 1 with no wait state, else ws + 1.
    always_comb begin
        extra = (ws == '0) ? CNT_W'(1) : CNT_W'(ws) + CNT_W'(1);
        start = req && !busy;
        done  = busy && (cnt == '0);
        stall = start || (busy && (cnt != '0));
    end

    // Sequence state: idle -> busy for `extra` cycles -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= extra - CNT_W'(1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_W'(1);
        end
    end

    // Capture address, data and direction once so the bus stays stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_rd    <= 1'b0;
            lat_wr    <= 1'b0;
        end else if (start) begin
            lat_addr  <= addr;
            lat_wdata <= wdata;
            lat_rd    <= rd;
            lat_wr    <= wr && !rd;
        end
    end

    // Drive the bus pins from registered state only (glitch-free strobes).
    always_comb begin
        bus_addr   = lat_addr;
        bus_wdata  = lat_wdata;
        bus_rd_n   = !(busy && lat_rd);
        bus_wr_n   = !(busy && lat_wr);
        bus_oe     = busy && lat_wr;
        rd_latched = lat_rd;
    end

    // Checker state: length of the current run of stall cycles.
    logic [RUN_W-1:0] stall_run;
    always_ff @(posedge clk) begin
        if (!rst_n)     stall_run <= '0;
        else if (stall) stall_run <= stall_run + RUN_W'(1);
        else            stall_run <= '0;
    end

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= RUN_W'(MAX_EXTRA)); // R6
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(rst_n)) |-> ($stable(bus_addr) && $stable(bus_wdata))); // R8
endmodule

// File: rtl/dmem_decoder.sv
// Data memory decoder top: routes core data accesses to register/I-O,
// internal SRAM (single cycle) or an external SRAM bus with wait states,
// and muxes the read data back to the core.
// Assumes at most one of core_rd/core_wr is high and that the core holds
// its request while core_stall is high.
module dmem_decoder
    import dmem_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int WS_W       = 2,
    parameter int REGIO_SIZE = 96,
    parameter int ISRAM_SIZE = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_rd,
    input  logic              core_wr,
    output logic              core_stall,
    output logic [DATA_W-1:0] core_rdata,
    input  logic              ext_en,
    input  logic [WS_W-1:0]   wait_sel,
    output logic              regio_sel,
    output logic              isram_sel,
    input  logic [DATA_W-1:0] regio_rdata,
    input  logic [DATA_W-1:0] isram_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dq_out,
    output logic              ext_dq_oe,
    input  logic [DATA_W-1:0] ext_dq_in,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    region_t rgn;
    logic    ext_req;
    logic    ext_busy;
    logic    ext_done;
    logic    ext_rd_lat;

    dmem_region_dec #(
        .ADDR_W     (ADDR_W),
        .REGIO_SIZE (REGIO_SIZE),
        .ISRAM_SIZE (ISRAM_SIZE)
    ) u_dec (
        .addr      (core_addr),
        .rd        (core_rd),
        .wr        (core_wr),
        .ext_en    (ext_en),
        .region    (rgn),
        .regio_sel (regio_sel),
        .isram_sel (isram_sel),
        .ext_req   (ext_req)
    );

    dmem_ext_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WS_W   (WS_W)
    ) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (ext_req),
        .addr       (core_addr),
        .wdata      (core_wdata),
        .rd         (core_rd),
        .wr         (core_wr),
        .ws         (wait_sel),
        .stall      (core_stall),
        .busy       (ext_busy),
        .done       (ext_done),
        .rd_latched (ext_rd_lat),
        .bus_addr   (ext_addr),
        .bus_wdata  (ext_dq_out),
        .bus_oe     (ext_dq_oe),
        .bus_rd_n   (ext_rd_n),
        .bus_wr_n   (ext_wr_n)
    );

    // Return read data from the region that serves this cycle's read.
    always_comb begin
        core_rdata = '0;
        if (ext_done && ext_rd_lat)        core_rdata = ext_dq_in;
        else if (core_rd && regio_sel)     core_rdata = regio_rdata;
        else if (core_rd && isram_sel)     core_rdata = isram_rdata;
    end

    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (regio_sel || isram_sel) |-> (ext_rd_n && ext_wr_n)); // R3
    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({regio_sel, isram_sel, ext_req})); // R4
    AST_DIS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rd || core_wr) && (rgn == RGN_EXT) && !ext_en && !ext_busy)
        |-> (!core_stall && core_rdata == '0)); // R9
    AST_DIS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rd || core_wr) && (rgn == RGN_EXT) && !ext_en && !ext_busy)
        |=> (ext_rd_n && ext_wr_n)); // R9
endmodule

// File: tb/dmem_decoder_bench.sv
module dmem_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] core_addr;
    logic [7:0]  core_wdata;
    logic        core_rd, core_wr, core_stall;
    logic [7:0]  core_rdata;
    logic        ext_en;
    logic [1:0]  wait_sel;
    logic        regio_sel, isram_sel;
    logic [7:0]  regio_rdata, isram_rdata;
    logic [15:0] ext_addr;
    logic [7:0]  ext_dq_out, ext_dq_in;
    logic        ext_dq_oe, ext_rd_n, ext_wr_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] bus_mem [256];
    logic [7:0] shadow  [256];

    always #2 clk = ~clk;

    dmem_decoder u_dmem_decoder (
        .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rd(core_rd), .core_wr(core_wr), .core_stall(core_stall),
        .core_rdata(core_rdata), .ext_en(ext_en), .wait_sel(wait_sel),
        .regio_sel(regio_sel), .isram_sel(isram_sel),
        .regio_rdata(regio_rdata), .isram_rdata(isram_rdata),
        .ext_addr(ext_addr), .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe),
        .ext_dq_in(ext_dq_in), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    // Internal memory stand-ins and external SRAM model.
    assign regio_rdata = core_addr[7:0] ^ 8'h11;
    assign isram_rdata = core_addr[7:0] ^ 8'h22;
    assign ext_dq_in   = bus_mem[ext_addr[7:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bus_mem[i] <= 8'(i) ^ 8'hC3;
        end else if (!ext_wr_n) begin
            bus_mem[ext_addr[7:0]] <= ext_dq_out;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Vector fields: {addr[28:13], rd[12], wr[11], wdata[10:3], en[2], ws[1:0]}
    localparam logic [28:0] VEC [0:15] = '{
        {16'h0000, 1'b1, 1'b0, 8'h00, 1'b1, 2'd0},
        {16'h005F, 1'b0, 1'b1, 8'h3C, 1'b1, 2'd0},
        {16'h0060, 1'b1, 1'b0, 8'h00, 1'b1, 2'd1},
        {16'h025F, 1'b0, 1'b1, 8'h12, 1'b1, 2'd3},
        {16'h0260, 1'b0, 1'b1, 8'hA5, 1'b1, 2'd0},
        {16'h0260, 1'b1, 1'b0, 8'h00, 1'b1, 2'd0},
        {16'h1234, 1'b0, 1'b1, 8'h77, 1'b0, 2'd1},
        {16'h1234, 1'b1, 1'b0, 8'h00, 1'b1, 2'd1},
        {16'h4000, 1'b0, 1'b1, 8'h5E, 1'b1, 2'd2},
        {16'h4000, 1'b1, 1'b0, 8'h00, 1'b1, 2'd3},
        {16'hFFFF, 1'b0, 1'b1, 8'h81, 1'b1, 2'd3},
        {16'hFFFF, 1'b1, 1'b0, 8'h00, 1'b1, 2'd2},
        {16'h8000, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0},
        {16'h025F, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0},
        {16'h0300, 1'b1, 1'b0, 8'h00, 1'b1, 2'd1},
        {16'h0040, 1'b0, 1'b1, 8'h99, 1'b0, 2'd2}
    };

    task automatic run_access(input logic [15:0] a, input bit rd, input bit wr,
                              input logic [7:0] wd, input bit en, input logic [1:0] ws);
        int rgn, extra, n;
        string tag;
        rgn   = (a < 16'd96) ? 0 : (a < 16'd608) ? 1 : 2;
        extra = (ws == 2'd0) ? 1 : int'(ws) + 1;
        @(negedge clk);
        core_addr = a; core_wdata = wd; core_rd = rd; core_wr = wr;
        ext_en = en; wait_sel = ws;
        #1;
        chk(regio_sel == (rgn == 0 && (rd || wr)), "R1", regio_sel, rgn == 0);
        chk(isram_sel == (rgn == 1 && (rd || wr)), "R2", isram_sel, rgn == 1);
        if (!(rgn == 2 && en)) begin
            tag = (rgn == 0) ? "R1" : (rgn == 1) ? "R2" : "R9";
            chk(core_stall == 1'b0, tag, core_stall, 0);
            chk(ext_rd_n && ext_wr_n, (rgn == 2) ? "R9" : "R3", {ext_rd_n, ext_wr_n}, 3);
            if (rd) begin
                logic [7:0] e;
                e = (rgn == 0) ? (a[7:0] ^ 8'h11) : (rgn == 1) ? (a[7:0] ^ 8'h22) : 8'h00;
                chk(core_rdata == e, tag, core_rdata, e);
            end
            @(negedge clk);
            #1;
            chk(ext_rd_n && ext_wr_n, (rgn == 2) ? "R9" : "R3", {ext_rd_n, ext_wr_n}, 3);
        end else begin
            chk(core_stall == 1'b1, "R4", core_stall, 1);
            n = 0;
            while (core_stall && n < 10) begin
                @(negedge clk);
                #1;
                n++;
                chk(ext_rd_n == !rd && ext_wr_n == !wr, "R7", {ext_rd_n, ext_wr_n}, {!rd, !wr});
                chk(ext_addr == a, "R4", ext_addr, a);
                if (wr) chk(ext_dq_oe && ext_dq_out == wd, "R8", ext_dq_out, wd);
            end
            chk(n == extra, (ws == 2'd0) ? "R5" : "R6", n, extra);
            if (rd) chk(core_rdata == shadow[a[7:0]], "R7", core_rdata, shadow[a[7:0]]);
            if (wr) shadow[a[7:0]] = wd;
        end
        @(negedge clk);
        core_rd = 1'b0; core_wr = 1'b0;
        #1;
        chk(ext_rd_n && ext_wr_n && !ext_dq_oe, "R8", {ext_rd_n, ext_wr_n, ext_dq_oe}, 6);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        wait (cyc >= 50000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; core_addr = '0; core_wdata = '0; core_rd = 1'b0; core_wr = 1'b0;
        ext_en = 1'b0; wait_sel = '0;
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'hC3;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        chk(ext_rd_n && ext_wr_n, "R10", {ext_rd_n, ext_wr_n}, 3);
        chk(!ext_dq_oe && !core_stall, "R10", {ext_dq_oe, core_stall}, 0);
        chk(ext_addr == 16'h0000, "R10", ext_addr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < 16; v++) begin
            run_access(VEC[v][28:13], VEC[v][12], VEC[v][11], VEC[v][10:3],
                       VEC[v][2], VEC[v][1:0]);
        end

        // R10: reset abandons an external read in flight
        @(negedge clk);
        core_addr = 16'h5000; core_rd = 1'b1; ext_en = 1'b1; wait_sel = 2'd3;
        @(negedge clk);
        #1;
        chk(ext_rd_n == 1'b0, "R7", ext_rd_n, 0);
        rst_n = 1'b0; core_rd = 1'b0;
        @(negedge clk);
        #1;
        chk(ext_rd_n && ext_wr_n && !ext_dq_oe, "R10", {ext_rd_n, ext_wr_n, ext_dq_oe}, 6);
        chk(ext_addr == 16'h0000 && !core_stall, "R10", ext_addr, 0);
        rst_n = 1'b1;

        // R5 after reset: a fresh zero-wait write still completes in 2 cycles
        run_access(16'h0261, 1'b0, 1'b1, 8'h4B, 1'b1, 2'd0);
        run_access(16'h0261, 1'b1, 1'b0, 8'h00, 1'b1, 2'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule